// File: doc/BRIEF.md
# Swizzled Scale Layout Writer

This block places one-byte block scales into memory in a tiled, row-interleaved arrangement that a matrix engine reads directly. Scale bytes arrive in logical row-major order, each tagged with its row and its scale-column index. For every byte the block computes the target byte address and issues a byte write on a simple valid/ready write port. When the last real scale byte has been accepted, it writes zero to every location that exists only because the matrix was padded, then pulses `done`.

The layout groups the scale matrix into tiles of 128 rows by 4 columns. Each tile fills 512 consecutive bytes, and the tiles follow one another row-major across the tile grid. Inside a tile the rows fall into four 32-row groups. The four rows that share the same position within their groups are stored side by side, each as four column bytes. Software writes the row count and the scale-column count together with a `start` pulse. From then on the block shows the padded footprint in bytes, so the caller can size the buffer.

The controller has four states. It starts in IDLE. On `start` it moves to STREAM, and in this step the configuration is latched. It moves from STREAM to FILL when the last real byte is accepted. It moves from FILL to DONE when the last padding row has been walked. From DONE it returns to IDLE after one cycle.

Top module: `swz_scale_writer`

## Requirements
- R1: Byte address = tile*512 + (row mod 32)*16 + ((row mod 128) div 32)*4 + (col mod 4), where tile = (row div 128)*ceil(cols/4) + (col div 4). Every write address is below `total_bytes`.
- R2: Inside a tile, bytes 0-3 hold row 0 columns 0-3, bytes 4-7 hold row 32, bytes 8-11 hold row 64, bytes 12-15 hold row 96, and byte 16 begins row 1.
- R3: `total_bytes` reads 0 after reset. From the cycle after `start` is accepted it reads ceil(M/128)*ceil(cols/4)*512, and it holds that value.
- R4: In STREAM, `in_ready` equals `wr_ready`, `wr_valid` follows `in_valid`, and `wr_data` carries `in_data`. Outside STREAM `in_ready` stays 0, so input offered in IDLE produces no write.
- R5: After the byte at row M-1, column cols-1 is accepted, the block writes 0x00 to every padded-grid location that holds no real scale, exactly once each. The order is rows ascending and, within a row, columns ascending.
- R6: `done` rises for exactly one cycle, in the cycle after the last padding step, and the block then returns to IDLE.
- R7: During FILL, a write held off by `wr_ready` low keeps `wr_valid` high and its address unchanged in the next cycle.
- R8: A `start` pulse outside IDLE is ignored, and `total_bytes` keeps the value latched earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and begin (IDLE only) |
| cfg_rows | input | ROW_W | Matrix row count M (at least 1) |
| cfg_cols | input | COL_W | Scale column count (at least 1) |
| total_bytes | output | ADDR_W | Padded layout size in bytes |
| in_valid | input | 1 | Scale byte offered |
| in_ready | output | 1 | Scale byte accepted this cycle |
| in_row | input | ROW_W | Logical row of the byte |
| in_col | input | COL_W | Logical scale column of the byte |
| in_data | input | 8 | Scale byte |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Write port accepts |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8 | Byte written |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in one cycle: acceptance of the final real byte, and the FILL cursor loading its start column. That same edge also decides whether the first zero write comes straight after it. The bench holds `wr_ready` low at random, so the final real byte is sometimes accepted only after several stalled cycles. The scoreboard then requires that the next write popped is the first padding location, with no gap and no repeat. A `start` pulse is also driven while STREAM is active, and the unchanged `total_bytes` and write sequence show that it was ignored.

// File: rtl/swz_pkg.sv
`timescale 1ns/1ps
package swz_pkg;
    localparam int TILE_ROWS  = 128;
    localparam int TILE_COLS  = 4;
    localparam int GRP_ROWS   = 32;
    localparam int TILE_BYTES = TILE_ROWS * TILE_COLS;
    localparam int ROW_PITCH  = TILE_COLS * (TILE_ROWS / GRP_ROWS);
    localparam int TR_SH      = $clog2(TILE_ROWS);
    localparam int TC_SH      = $clog2(TILE_COLS);
    localparam int GR_SH      = $clog2(GRP_ROWS);

    typedef enum logic [1:0] {
        S_IDLE,
        S_STREAM,
        S_FILL,
        S_DONE
    } wr_state_t;
endpackage

// File: rtl/swz_geom.sv
`timescale 1ns/1ps
module swz_geom
    import swz_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic [ROW_W-1:0]  rows_m,
    input  logic [COL_W-1:0]  cols_c,
    output logic [ROW_W:0]    pad_rows,
    output logic [COL_W:0]    pad_cols,
    output logic [COL_W:0]    col_blocks,
    output logic [ADDR_W-1:0] total
);
    logic [ROW_W:0] rsum;
    logic [ROW_W:0] rblk;
    logic [COL_W:0] csum;

    always_comb begin
        rsum       = {1'b0, rows_m} + (ROW_W+1)'(TILE_ROWS - 1);
        rblk       = rsum >> TR_SH;
        pad_rows   = rblk << TR_SH;
        csum       = {1'b0, cols_c} + (COL_W+1)'(TILE_COLS - 1);
        col_blocks = csum >> TC_SH;
        pad_cols   = col_blocks << TC_SH;
        total      = ADDR_W'(rblk) * ADDR_W'(col_blocks) * ADDR_W'(TILE_BYTES);
    end
endmodule

// File: rtl/swz_tile_addr.sv
`timescale 1ns/1ps
module swz_tile_addr
    import swz_pkg::*;
#(
    parameter int RW     = 17,
    parameter int CW     = 13,
    parameter int ADDR_W = 32
) (
    input  logic [RW-1:0]     row,
    input  logic [CW-1:0]     col,
    input  logic [CW-1:0]     col_blocks,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] tile_idx;
    logic [ADDR_W-1:0] sub_row;
    logic [ADDR_W-1:0] group;
    logic [ADDR_W-1:0] lane;

    always_comb begin
        tile_idx = ADDR_W'(row >> TR_SH) * ADDR_W'(col_blocks) + ADDR_W'(col >> TC_SH);
        sub_row  = ADDR_W'(row[GR_SH-1:0]);
        group    = ADDR_W'(row[TR_SH-1:GR_SH]);
        lane     = ADDR_W'(col[TC_SH-1:0]);
        addr     = tile_idx * ADDR_W'(TILE_BYTES) + sub_row * ADDR_W'(ROW_PITCH)
                 + group * ADDR_W'(TILE_COLS) + lane;
    end
endmodule

// File: rtl/swz_pad_cursor.sv
`timescale 1ns/1ps
module swz_pad_cursor #(
    parameter int ROW_W = 16,
    parameter int COL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [ROW_W-1:0] rows_m,
    input  logic [COL_W-1:0] cols_c,
    input  logic [ROW_W:0]   pad_rows,
    input  logic [COL_W:0]   pad_cols,
    output logic [ROW_W:0]   cur_r,
    output logic [COL_W:0]   cur_c,
    output logic             emit,
    output logic             row_end,
    output logic             last_row
);
    logic [ROW_W:0] r_next;

    always_comb begin
        r_next   = cur_r + 1'b1;
        emit     = cur_c < pad_cols;
        row_end  = !emit || (cur_c == pad_cols - 1'b1);
        last_row = cur_r == pad_rows - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_r <= '0;
            cur_c <= '0;
        end else if (load) begin
            cur_r <= '0;
            cur_c <= {1'b0, cols_c};
        end else if (advance) begin
            if (row_end) begin
                cur_r <= r_next;
                cur_c <= (r_next < {1'b0, rows_m}) ? {1'b0, cols_c} : '0;
            end else begin
                cur_c <= cur_c + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swz_scale_writer.sv
`timescale 1ns/1ps
module swz_scale_writer
    import swz_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 12,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [COL_W-1:0]  cfg_cols,
    output logic [ADDR_W-1:0] total_bytes,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [7:0]        in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done
);
    wr_state_t        state_q, state_d;
    logic [ROW_W-1:0] m_q;
    logic [COL_W-1:0] c_q;
    logic [ROW_W:0]   pad_rows;
    logic [COL_W:0]   pad_cols;
    logic [COL_W:0]   col_blocks;
    logic [ROW_W:0]   cur_r;
    logic [COL_W:0]   cur_c;
    logic             emit, row_end, last_row;
    logic             last_real, fill_adv, finishing;
    logic [ROW_W:0]   map_row;
    logic [COL_W:0]   map_col;

    swz_geom #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_geom (
        .rows_m(m_q), .cols_c(c_q), .pad_rows(pad_rows), .pad_cols(pad_cols),
        .col_blocks(col_blocks), .total(total_bytes)
    );

    swz_pad_cursor #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(last_real), .advance(fill_adv),
        .rows_m(m_q), .cols_c(c_q), .pad_rows(pad_rows), .pad_cols(pad_cols),
        .cur_r(cur_r), .cur_c(cur_c), .emit(emit), .row_end(row_end),
        .last_row(last_row)
    );

    swz_tile_addr #(.RW(ROW_W+1), .CW(COL_W+1), .ADDR_W(ADDR_W)) u_map (
        .row(map_row), .col(map_col), .col_blocks(col_blocks), .addr(wr_addr)
    );

    // Configuration is captured only on the IDLE->STREAM step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            c_q <= '0;
        end else if (state_q == S_IDLE && start) begin
            m_q <= cfg_rows;
            c_q <= cfg_cols;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        wr_valid  = 1'b0;
        wr_data   = 8'h00;
        done      = 1'b0;
        fill_adv  = 1'b0;
        map_row   = cur_r;
        map_col   = cur_c;
        last_real = 1'b0;
        finishing = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_STREAM;
            end
            S_STREAM: begin
                in_ready  = wr_ready;
                wr_valid  = in_valid;
                wr_data   = in_data;
                map_row   = {1'b0, in_row};
                map_col   = {1'b0, in_col};
                last_real = in_valid && wr_ready
                          && in_row == ROW_W'(m_q - 1'b1)
                          && in_col == COL_W'(c_q - 1'b1);
                if (last_real) state_d = S_FILL;
            end
            S_FILL: begin
                wr_valid  = emit;
                fill_adv  = emit ? wr_ready : 1'b1;
                finishing = fill_adv && row_end && last_row;
                if (finishing) state_d = S_DONE;
            end
            S_DONE: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assert_addr_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr < total_bytes);

    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !in_valid) |-> wr_data == 8'h00);

    assert_col_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_FILL |-> cur_c <= pad_cols);

    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FILL && wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done || $past(done)) |-> !in_ready);
endmodule

// File: tb/swz_scale_writer_test.sv
`timescale 1ns/1ps
module swz_scale_writer_test;
    localparam int ROW_W  = 16;
    localparam int COL_W  = 12;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ROW_W-1:0]  cfg_rows = '0;
    logic [COL_W-1:0]  cfg_cols = '0;
    logic [ADDR_W-1:0] total_bytes;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ROW_W-1:0]  in_row = '0;
    logic [COL_W-1:0]  in_col = '0;
    logic [7:0]        in_data = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              done;

    swz_scale_writer #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
        .cfg_cols(cfg_cols), .total_bytes(total_bytes), .in_valid(in_valid),
        .in_ready(in_ready), .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    addr;
        int    data;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    int   done_cnt = 0;
    bit   prev_stall = 1'b0;
    bit   prev_done = 1'b0;
    int   prev_addr = 0;
    bit   rand_ready = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int r, input int c, input int ncb);
        return ((r / 128) * ncb + (c / 4)) * 512 + (r % 32) * 16 + ((r % 128) / 32) * 4 + (c % 4);
    endfunction

    function automatic int pattern(input int r, input int c);
        return (r * 7 + c * 13 + 1) & 255;
    endfunction

    // Write-port readiness toggles at random after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            wr_ready = rand_ready ? (($urandom % 10) < 7) : 1'b1;
        end
    end

    // Monitor: scoreboard pop and cycle-level checks, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(wr_valid == 1'b1, "R7 held valid", int'(wr_valid), 1);
                chk(int'(wr_addr) == prev_addr, "R7 held addr", int'(wr_addr), prev_addr);
            end
            if (done && prev_done) chk(1'b0, "R6 done width", 1, 0);
            if (done) done_cnt++;
            prev_done  = done;
            prev_stall = wr_valid && !wr_ready && !in_valid;
            prev_addr  = int'(wr_addr);
            if (wr_valid && wr_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 unexpected write", int'(wr_addr), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(int'(wr_addr) == e.addr, {e.req, " R1/R2 addr"}, int'(wr_addr), e.addr);
                    chk(int'(wr_data) == e.data, {e.req, " data"}, int'(wr_data), e.data);
                end
            end
        end
    end

    task automatic send(input int r, input int c);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_row   = ROW_W'(r);
        in_col   = COL_W'(c);
        in_data  = 8'(pattern(r, c));
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic run_case(input int m, input int cc);
        int pr, pc, ncb, total, start_done;
        ncb   = (cc + 3) / 4;
        pc    = ncb * 4;
        pr    = ((m + 127) / 128) * 128;
        total = (pr / 128) * ncb * 512;
        for (int r = 0; r < m; r++)
            for (int c = 0; c < cc; c++)
                q.push_back('{exp_addr(r, c, ncb), pattern(r, c), "R4"});
        for (int r = 0; r < pr; r++)
            for (int c = 0; c < pc; c++)
                if (!(r < m && c < cc))
                    q.push_back('{exp_addr(r, c, ncb), 0, "R5"});
        start_done = done_cnt;
        @(posedge clk);
        #1;
        cfg_rows = ROW_W'(m);
        cfg_cols = COL_W'(cc);
        start    = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        @(negedge clk);
        chk(int'(total_bytes) == total, "R3 total", int'(total_bytes), total);
        send(0, 0);
        // R8: start with another configuration while busy.
        @(posedge clk);
        #1;
        cfg_rows = ROW_W'(m + 300);
        cfg_cols = COL_W'(cc + 9);
        start    = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        @(negedge clk);
        chk(int'(total_bytes) == total, "R8 total kept", int'(total_bytes), total);
        for (int r = 0; r < m; r++)
            for (int c = 0; c < cc; c++)
                if (r != 0 || c != 0) send(r, c);
        for (int i = 0; i < 20000 && done_cnt == start_done; i++) @(negedge clk);
        chk(done_cnt == start_done + 1, "R6 done pulse", done_cnt - start_done, 1);
        chk(q.size() == 0, "R5 all padding written", q.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done low after", int'(done), 0);
        chk(int'(total_bytes) == total, "R3 total held", int'(total_bytes), total);
        q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(total_bytes == '0, "R3 reset total", int'(total_bytes), 0);
        chk(done == 1'b0, "R6 reset done", int'(done), 0);
        chk(wr_valid == 1'b0, "R4 reset wr_valid", int'(wr_valid), 0);
        // R4: input offered while idle is not accepted and makes no write.
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = 8'hA5;
        repeat (3) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R4 idle in_ready", int'(in_ready), 0);
            chk(wr_valid == 1'b0, "R4 idle wr_valid", int'(wr_valid), 0);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        run_case(5, 3);
        run_case(130, 6);
        run_case(128, 4);
        run_case(1, 1);
        rand_ready = 1'b0;
        run_case(33, 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule